// File: doc/BRIEF.md
# NAND Sector Hamming Parity Generator

This block builds a 24-bit Hamming check code for one 512-byte NAND sector while the bytes go past on an 8-bit stream. A start strobe opens a new sector, and each cycle with the byte-valid input high adds one byte. Two sets of parities build up as the bytes arrive. Column parities are taken over the bit index inside each byte. Row parities are taken over the byte's position in the sector. Every parity level has an even half and an odd half.

The accumulated halves can be read in two forms. The raw parity word holds the even halves in its low half-word and the odd halves in its high half-word. The packed code holds the halves in a fixed three-byte order and inverts every bit, ready to be written to the spare area. The done output rises once the last byte of the sector has been taken in.

Top module: `nand_ecc_gen`

## Requirements
- R1: While reset is held, `raw_par` is all zero, `ecc_code` is 24'hFFFFFF and `done` is 0.
- R2: A cycle with `start` high sets `raw_par` to zero and `done` to 0 from the next cycle on. A byte offered in that same cycle is not counted, and the next accepted byte has address 0.
- R3: Only a cycle with `byte_vld` high, `start` low and `done` low changes `raw_par`. In every other cycle the parities hold their value.
- R4: Column parity for level k (k = 0, 1, 2) covers the bits whose index inside the byte has bit k set (odd half, `raw_par[16+k]`) or bit k clear (even half, `raw_par[k]`).
- R5: Row parity for level k (k = 0..8) folds the XOR of every bit of a byte into the odd half `raw_par[19+k]` when bit k of the byte's address is set, and into the even half `raw_par[3+k]` when it is clear. The address counts accepted bytes from 0 after the last start.
- R6: `raw_par[15:12]` is always zero.
- R7: `ecc_code[7:0]`, from LSB to MSB, holds row levels 0..3 as the pairs (even, odd). `ecc_code[15:8]` holds row levels 4..7 in the same way. `ecc_code[23:16]` holds row level 8 and then column levels 0..2, each as (even, odd).
- R8: Every `ecc_code` bit is the inverse of the parity half placed there, so an all-zero sector gives 24'hFFFFFF.
- R9: `done` rises in the cycle after the 512th accepted byte and stays high until the next start.
- R10: Bytes offered after the 512th byte, before a new start, leave `raw_par` unchanged.
- R11: For every level, the XOR of its even and odd halves equals the XOR of all bits accepted so far.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clears the parities and the byte address for a new sector |
| byte_vld | input | 1 | The byte on `byte_in` is offered in this cycle |
| byte_in | input | 8 | Sector data byte |
| raw_par | output | 28 | Raw parities: even halves in bits 11:0, odd halves in bits 27:16 |
| ecc_code | output | 24 | Packed and inverted three-byte check code |
| done | output | 1 | A full sector has been accumulated |

## Verification
The properties assume that `start` and `byte_vld` are never unknown outside reset. They also assume that a sector is closed only by a new start, never by letting a reset run partway through it. The bench drives every input from the falling edge and holds it for a whole cycle. It starts each sector with a start pulse, and it offers extra bytes past the end of a sector only to check that they are ignored. Random sectors, with and without idle gaps between bytes, are compared against a bit-level model. Directed cases cover an all-zero sector, a start that arrives together with a byte, and a restart in the middle of a sector.

// File: rtl/nand_ecc_pkg.sv
// Shared constants and helpers for the sector parity generator.
// Assumes the byte width and the sector size are powers of two.
package nand_ecc_pkg;

    // Width of each half of the raw parity word
    localparam int unsigned ECC_HALF_W = 16;

    // Returns 1 when bit lvl of idx is set; picks the odd or the even half
    function automatic bit idx_bit_set(input int unsigned idx, input int unsigned lvl);
        return ((idx >> lvl) & 1) == 1;
    endfunction

endpackage

// File: rtl/nand_ecc_seq.sv
// Sector sequencer: counts accepted bytes and marks the end of the sector.
// Assumes start has priority over byte_vld. Bytes beyond the sector are refused.
module nand_ecc_seq #(
    parameter int unsigned SECTOR_BYTES = 512,
    parameter int unsigned CNT_W        = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             byte_vld,
    output logic             accept,
    output logic [CNT_W-1:0] addr,
    output logic             full
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SECTOR_BYTES);

    logic [CNT_W-1:0] cnt_q;

    // Acceptance decision for the byte offered this cycle
    always_comb begin
        full   = (cnt_q == LAST_CNT);
        accept = byte_vld && !start && !full;
        addr   = cnt_q;
    end

    // Byte address counter, cleared by reset or start
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/nand_ecc_col_par.sv
// Column parity accumulator: for every level of the bit index inside a
// byte, it XORs into the odd half the bits whose index has that level set,
// and into the even half the others. Assumes DATA_W is a power of two.
module nand_ecc_col_par
    import nand_ecc_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned COL_LVLS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                accept,
    input  logic [DATA_W-1:0]   byte_in,
    output logic [COL_LVLS-1:0] par_e,
    output logic [COL_LVLS-1:0] par_o
);
    logic [COL_LVLS-1:0] step_e;
    logic [COL_LVLS-1:0] step_o;

    for (genvar k = 0; k < COL_LVLS; k++) begin : g_lvl
        // Split the byte's bits by bit k of their index
        always_comb begin
            step_e[k] = 1'b0;
            step_o[k] = 1'b0;
            for (int j = 0; j < DATA_W; j++) begin
                if (idx_bit_set(j, k)) begin
                    step_o[k] = step_o[k] ^ byte_in[j];
                end else begin
                    step_e[k] = step_e[k] ^ byte_in[j];
                end
            end
        end
    end

    // Accumulate the column parities over the accepted bytes
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            par_e <= '0;
            par_o <= '0;
        end else if (accept) begin
            par_e <= par_e ^ step_e;
            par_o <= par_o ^ step_o;
        end
    end

endmodule

// File: rtl/nand_ecc_row_par.sv
// Row parity accumulator: folds each byte's full parity into the odd or the
// even half of every level, chosen by the matching bit of the byte address.
// Assumes addr is the index of the byte accepted this cycle.
module nand_ecc_row_par #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ROW_LVLS = 9,
    parameter int unsigned CNT_W    = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                accept,
    input  logic [DATA_W-1:0]   byte_in,
    input  logic [CNT_W-1:0]    addr,
    output logic [ROW_LVLS-1:0] par_e,
    output logic [ROW_LVLS-1:0] par_o
);
    logic                byte_par;
    logic [ROW_LVLS-1:0] step_e;
    logic [ROW_LVLS-1:0] step_o;

    // Parity of the whole byte
    always_comb byte_par = ^byte_in;

    for (genvar k = 0; k < ROW_LVLS; k++) begin : g_lvl
        // Steer the byte parity by address bit k
        always_comb begin
            step_o[k] = addr[k] & byte_par;
            step_e[k] = ~addr[k] & byte_par;
        end
    end

    // Accumulate the row parities over the accepted bytes
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            par_e <= '0;
            par_o <= '0;
        end else if (accept) begin
            par_e <= par_e ^ step_e;
            par_o <= par_o ^ step_o;
        end
    end

endmodule

// File: rtl/nand_ecc_pack.sv
// Code packer: orders the parity halves as row levels first, then column
// levels, each as an (even, odd) pair from the LSB up, and inverts them.
// Inputs are indexed with the column levels low and the row levels above.
module nand_ecc_pack #(
    parameter int unsigned COL_LVLS = 3,
    parameter int unsigned ROW_LVLS = 9,
    parameter int unsigned LVLS     = COL_LVLS + ROW_LVLS,
    parameter int unsigned CODE_W   = 2 * LVLS
) (
    input  logic [LVLS-1:0]   par_e,
    input  logic [LVLS-1:0]   par_o,
    output logic [CODE_W-1:0] code
);
    for (genvar m = 0; m < LVLS; m++) begin : g_slot
        localparam int unsigned SRC = (m < ROW_LVLS) ? (COL_LVLS + m) : (m - ROW_LVLS);
        // Place one inverted pair in slot m
        always_comb begin
            code[2*m]   = ~par_e[SRC];
            code[2*m+1] = ~par_o[SRC];
        end
    end

endmodule

// File: rtl/nand_ecc_gen.sv
// Sector Hamming parity generator, top level. It streams one sector's bytes
// into the column and row accumulators and shows the result both as a raw
// split word and as a packed inverted code.
// Assumes inputs change away from the rising clock edge.
module nand_ecc_gen
    import nand_ecc_pkg::*;
#(
    parameter  int unsigned DATA_W       = 8,
    parameter  int unsigned SECTOR_BYTES = 512,
    localparam int unsigned COL_LVLS     = $clog2(DATA_W),
    localparam int unsigned ROW_LVLS     = $clog2(SECTOR_BYTES),
    localparam int unsigned LVLS         = COL_LVLS + ROW_LVLS,
    localparam int unsigned RAW_W        = ECC_HALF_W + LVLS,
    localparam int unsigned CODE_W       = 2 * LVLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_in,
    output logic [RAW_W-1:0]  raw_par,
    output logic [CODE_W-1:0] ecc_code,
    output logic              done
);
    localparam int unsigned CNT_W = ROW_LVLS + 1;

    logic                accept;
    logic [CNT_W-1:0]    addr;
    logic [COL_LVLS-1:0] col_e, col_o;
    logic [ROW_LVLS-1:0] row_e, row_o;
    logic [LVLS-1:0]     all_e, all_o;

    nand_ecc_seq #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .CNT_W        (CNT_W)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .byte_vld (byte_vld),
        .accept   (accept),
        .addr     (addr),
        .full     (done)
    );

    nand_ecc_col_par #(
        .DATA_W   (DATA_W),
        .COL_LVLS (COL_LVLS)
    ) col_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .accept  (accept),
        .byte_in (byte_in),
        .par_e   (col_e),
        .par_o   (col_o)
    );

    nand_ecc_row_par #(
        .DATA_W   (DATA_W),
        .ROW_LVLS (ROW_LVLS),
        .CNT_W    (CNT_W)
    ) row_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .accept  (accept),
        .byte_in (byte_in),
        .addr    (addr),
        .par_e   (row_e),
        .par_o   (row_o)
    );

    // Join the column and row halves, column levels in the low bits
    always_comb begin
        all_e = {row_e, col_e};
        all_o = {row_o, col_o};
    end

    // Raw word: even halves low, odd halves from the upper half-word
    always_comb begin
        raw_par                    = '0;
        raw_par[LVLS-1:0]          = all_e;
        raw_par[ECC_HALF_W +: LVLS] = all_o;
    end

    nand_ecc_pack #(
        .COL_LVLS (COL_LVLS),
        .ROW_LVLS (ROW_LVLS),
        .LVLS     (LVLS),
        .CODE_W   (CODE_W)
    ) pack_i (
        .par_e (all_e),
        .par_o (all_o),
        .code  (ecc_code)
    );

endmodule

// File: rtl/nand_ecc_gen_chk.sv
// Property checker for nand_ecc_gen, attached through bind.
// Assumes control inputs are known whenever reset is released.
module nand_ecc_gen_chk #(
    parameter int unsigned LVLS   = 12,
    parameter int unsigned HALF_W = 16,
    parameter int unsigned RAW_W  = 28,
    parameter int unsigned CODE_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              byte_vld,
    input logic [RAW_W-1:0]  raw_par,
    input logic [CODE_W-1:0] ecc_code,
    input logic              done
);
    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (raw_par == '0) && !done);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !byte_vld) |=> $stable(raw_par) && $stable(done));

    // R10
    full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(raw_par));

    // R9
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(byte_vld) && !$past(start));

    // R8
    zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_par == '0) |-> (ecc_code == {CODE_W{1'b1}}));

    // R11
    for (genvar k = 1; k < LVLS; k++) begin : g_agree
        level_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_par[k] ^ raw_par[HALF_W+k]) == (raw_par[0] ^ raw_par[HALF_W]));
    end

endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(
    .LVLS   (LVLS),
    .HALF_W (nand_ecc_pkg::ECC_HALF_W),
    .RAW_W  (RAW_W),
    .CODE_W (CODE_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .byte_vld (byte_vld),
    .raw_par  (raw_par),
    .ecc_code (ecc_code),
    .done     (done)
);

// File: tb/nand_ecc_gen_tb_top.sv
module nand_ecc_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [27:0] raw_par;
    logic [23:0] ecc_code;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] mem [NBYTES];

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_ecc_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .raw_par  (raw_par),
        .ecc_code (ecc_code),
        .done     (done)
    );

    // Expected raw word over the first n bytes of mem
    function automatic logic [27:0] model_raw(input int n);
        logic [27:0] r = '0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = mem[i];
            for (int k = 0; k < 3; k++)
                for (int j = 0; j < 8; j++)
                    if (((j >> k) & 1) == 1) r[16+k] = r[16+k] ^ b[j];
                    else                     r[k]    = r[k] ^ b[j];
            for (int k = 0; k < 9; k++)
                if (((i >> k) & 1) == 1) r[19+k] = r[19+k] ^ (^b);
                else                     r[3+k]  = r[3+k] ^ (^b);
        end
        return r;
    endfunction

    // Expected packed code: slots m<9 are row levels, then column levels
    function automatic logic [23:0] model_code(input logic [27:0] r);
        logic [23:0] c;
        for (int m = 0; m < 12; m++) begin
            int src = (m < 9) ? (3 + m) : (m - 9);
            c[2*m]   = ~r[src];
            c[2*m+1] = ~r[16+src];
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, input bit gap);
        byte_vld = 1'b1;
        byte_in  = b;
        @(negedge clk);
        byte_vld = 1'b0;
        if (gap) @(negedge clk);
    endtask

    task automatic send(input int n, input bit gaps);
        pulse_start();
        for (int i = 0; i < n; i++) push(mem[i], gaps && ($urandom % 3 == 0));
    endtask

    task automatic check_state(input int n, input string tag);
        logic [27:0] er = model_raw(n);
        chk(raw_par == er, {tag, " raw (R4 R5)"}, 32'(raw_par), 32'(er));
        chk(ecc_code == model_code(er), {tag, " code (R7 R8)"}, 32'(ecc_code), 32'(model_code(er)));
        chk(done == (n == NBYTES), {tag, " done R9"}, 32'(done), 32'(n == NBYTES));
        chk(raw_par[15:12] == 4'h0, {tag, " pad R6"}, 32'(raw_par[15:12]), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [27:0] hold;
        bit          tp;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(raw_par == '0, "R1 raw in reset", 32'(raw_par), 32'h0);
        chk(ecc_code == 24'hFFFFFF, "R1 code in reset", 32'(ecc_code), 32'hFFFFFF);
        chk(done == 1'b0, "R1 done in reset", 32'(done), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // All-zero sector, R8
        for (int i = 0; i < NBYTES; i++) mem[i] = 8'h00;
        send(NBYTES, 1'b0);
        chk(ecc_code == 24'hFFFFFF, "R8 zero sector code", 32'(ecc_code), 32'hFFFFFF);
        check_state(NBYTES, "zero");

        // Random sectors, back-to-back and with gaps
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < NBYTES; i++) mem[i] = 8'($urandom);
            send(NBYTES, s[0]);
            check_state(NBYTES, "random");
            tp = 1'b0;
            for (int i = 0; i < NBYTES; i++) tp = tp ^ (^mem[i]);
            for (int k = 0; k < 12; k++)
                chk((raw_par[k] ^ raw_par[16+k]) == tp, "R11 level total parity",
                    32'(raw_par[k] ^ raw_par[16+k]), 32'(tp));
        end

        // R10 bytes beyond the sector are ignored
        hold = raw_par;
        for (int i = 0; i < 6; i++) push(8'($urandom | 1), 1'b0);
        chk(raw_par == hold, "R10 overrun ignored", 32'(raw_par), 32'(hold));
        chk(done == 1'b1, "R9 done held", 32'(done), 32'h1);

        // Single bytes walking address bits, R5
        for (int i = 0; i < NBYTES; i++) mem[i] = 8'h00;
        mem[0] = 8'h01; mem[1] = 8'h80; mem[170] = 8'h07; mem[511] = 8'h10;
        send(NBYTES, 1'b0);
        check_state(NBYTES, "sparse R5");

        // Partial sector, idle cycles, then restart midway (R3, R2)
        for (int i = 0; i < NBYTES; i++) mem[i] = 8'($urandom);
        send(100, 1'b1);
        check_state(100, "partial R3");
        hold = raw_par;
        repeat (5) @(negedge clk);
        chk(raw_par == hold, "R3 idle hold", 32'(raw_par), 32'(hold));
        pulse_start();
        chk(raw_par == '0, "R2 restart clears raw", 32'(raw_par), 32'h0);
        chk(done == 1'b0, "R2 restart clears done", 32'(done), 32'h0);

        // R2 byte offered with start is dropped; next byte is address 0
        start = 1'b1; byte_vld = 1'b1; byte_in = 8'hFF;
        @(negedge clk);
        start = 1'b0; byte_vld = 1'b0;
        chk(raw_par == '0, "R2 byte with start dropped", 32'(raw_par), 32'h0);
        push(8'h01, 1'b0);
        chk(raw_par == 28'h0000FFF, "R2 next byte at address 0", 32'(raw_par), 32'hFFF);

        // Full random sector after restart confirms R9 timing on 512th byte
        for (int i = 0; i < NBYTES; i++) mem[i] = 8'($urandom);
        send(NBYTES - 1, 1'b0);
        chk(done == 1'b0, "R9 not done after 511", 32'(done), 32'h0);
        push(mem[NBYTES-1], 1'b0);
        check_state(NBYTES, "final");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule